// File: doc/BRIEF.md
# Byte ALU with Per-Operation Flag Update

This block is the purely combinational arithmetic and logic stage of a small load/store CPU. Each cycle it receives two byte operands, a separate carry input, the six condition flags currently held by the core (half-carry, sign, overflow, negative, zero, carry) and a five-bit operation select. It returns the byte result, the new flag set and a write-enable telling the register file whether the result is to be stored.

Every operation owns a fixed subset of the flags. Flags outside that subset pass from `flags_in` to `flags_out` unchanged, so the core can always write `flags_out` back to its flag register. The irregular parts are deliberate: complement forces carry high, increment and decrement leave carry alone, compares update flags without a write, and nibble swap leaves every flag alone. The data width is a parameter, with the half-carry tap and swap boundary placed at the middle bit. Its default is 8.

Flag vector layout used on both flag ports: bit 0 = C, bit 1 = Z, bit 2 = N, bit 3 = V, bit 4 = S, bit 5 = H.

Top module: `alu8`

## Requirements
- R1: Op 0 (add) yields a+b and op 1 (add with carry) yields a+b+carry_in, modulo 256. All six flags are updated. C is the carry out of bit 7, H is the carry out of bit 3, and V is set when both operands have the same sign and the result's sign differs.
- R2: Op 2 (subtract) yields a-b and op 3 (subtract with carry) yields a-b-carry_in, modulo 256. All six flags are updated. C is set when the unsigned difference is negative, H is the borrow into bit 4, and V is set when the signed difference is outside -128..127.
- R3: Op 4 (compare) and op 5 (compare with carry) produce the same flags as ops 2 and 3 and hold result_we low. Every other op from 0 to 18 raises result_we.
- R4: Ops 6, 7 and 8 (AND, OR, XOR) clear V and update Z, N and S. C and H keep their incoming values.
- R5: Op 9 (complement) yields 255-a, sets C, clears V, and updates Z, N and S. H is kept.
- R6: Op 10 (negate) yields 0-a modulo 256 and updates all six flags as for a subtraction from zero. C is set whenever a is nonzero.
- R7: Op 11 (increment) and op 12 (decrement) update only Z, N, V and S. V is set exactly for increment of 0x7F and decrement of 0x80.
- R8: Op 13 (shift left) fills bit 0 with 0 and op 14 (shift right) fills bit 7 with 0. C receives the bit shifted out, V becomes N xor C, and Z, N, C, V and S are updated while H is kept.
- R9: Op 15 (rotate left) moves carry_in into bit 0 and bit 7 into C. Op 16 (rotate right) moves carry_in into bit 7 and bit 0 into C. Flags follow the same rules as R8.
- R10: Op 17 (arithmetic shift right) keeps bit 7, moves bits 7..1 into bits 6..0, and puts bit 0 into C. Flags follow the same rules as R8.
- R11: Op 18 (swap) exchanges the low and high nibbles of a, and flags_out equals flags_in.
- R12: Whenever an op updates N or V, S equals N xor V and Z is set exactly when the result is zero.
- R13: Op codes 19 to 31 are idle: result is 0, result_we is low and flags_out equals flags_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation select, codes 0..18 active |
| opnd_a | input | 8 | First operand, also the single operand of unary ops |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Carry for add/subtract with carry and rotates |
| flags_in | input | 6 | Current flags {H,S,V,N,Z,C} |
| result | output | 8 | Operation result |
| flags_out | output | 6 | Updated flags {H,S,V,N,Z,C} |
| result_we | output | 1 | High when the result is to be written back |

## Verification
The embedded assertions watch properties that hold on every evaluation: the carry of an add or subtract agrees with an unsigned comparison of the operands, compares never raise the write-enable, swap and idle codes pass the flags through, logic and increment/decrement ops keep C and H, complement sets C, and S always matches N xor V when it is updated. The exact result bytes and the half-carry and overflow values can only be shown by the bench's directed scenarios and its operand sweep. These include the 0x7F/0x80 overflow edges, borrows crossing the nibble boundary, and carry_in being fed into rotates, all compared against an independent integer model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   localparam int FLAG_W = 6;
   localparam int F_C = 0;
   localparam int F_Z = 1;
   localparam int F_N = 2;
   localparam int F_V = 3;
   localparam int F_S = 4;
   localparam int F_H = 5;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_SUB  = 5'd2,
      OP_SBC  = 5'd3,
      OP_CMP  = 5'd4,
      OP_CPC  = 5'd5,
      OP_AND  = 5'd6,
      OP_OR   = 5'd7,
      OP_XOR  = 5'd8,
      OP_COM  = 5'd9,
      OP_NEG  = 5'd10,
      OP_INC  = 5'd11,
      OP_DEC  = 5'd12,
      OP_LSL  = 5'd13,
      OP_LSR  = 5'd14,
      OP_ROL  = 5'd15,
      OP_ROR  = 5'd16,
      OP_ASR  = 5'd17,
      OP_SWAP = 5'd18
   } alu_op_e;

   typedef enum logic [1:0] {
      GRP_NONE  = 2'd0,
      GRP_ARITH = 2'd1,
      GRP_LOGIC = 2'd2,
      GRP_SHIFT = 2'd3
   } alu_grp_e;

   // logic unit selects
   localparam logic [1:0] LG_AND = 2'd0;
   localparam logic [1:0] LG_OR  = 2'd1;
   localparam logic [1:0] LG_XOR = 2'd2;
   localparam logic [1:0] LG_NOT = 2'd3;

   // shift unit selects
   localparam logic [2:0] SH_LSL  = 3'd0;
   localparam logic [2:0] SH_LSR  = 3'd1;
   localparam logic [2:0] SH_ROL  = 3'd2;
   localparam logic [2:0] SH_ROR  = 3'd3;
   localparam logic [2:0] SH_ASR  = 3'd4;
   localparam logic [2:0] SH_SWAP = 3'd5;

   // which flags an op owns, bit order {H,S,V,N,Z,C}
   function automatic logic [FLAG_W-1:0] flag_mask(input logic [4:0] op);
      logic [FLAG_W-1:0] m;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC,
         OP_CMP, OP_CPC, OP_NEG:          m = 6'b111111;
         OP_AND, OP_OR, OP_XOR,
         OP_INC, OP_DEC:                  m = 6'b011110;
         OP_COM, OP_LSL, OP_LSR,
         OP_ROL, OP_ROR, OP_ASR:          m = 6'b011111;
         default:                         m = 6'b000000;
      endcase
      return m;
   endfunction

   function automatic logic writes_back(input logic [4:0] op);
      return (op <= OP_SWAP) && (op != OP_CMP) && (op != OP_CPC);
   endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             ci,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             c_out,
   output logic             h_out,
   output logic             v_out
);
   localparam int MSB = WIDTH - 1;
   localparam int HB  = WIDTH / 2 - 1;

   generate
      if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
         $error("alu8_addsub: WIDTH must be even and at least 4");
      end
   endgenerate

   logic [WIDTH:0] wide;

   always_comb begin
      if (sub) wide = {1'b0, x} - {1'b0, y} - {{WIDTH{1'b0}}, ci};
      else     wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
   end

   assign sum   = wide[WIDTH-1:0];
   assign c_out = wide[WIDTH];

   always_comb begin
      if (sub) begin
         h_out = (~x[HB] & y[HB]) | (y[HB] & sum[HB]) | (sum[HB] & ~x[HB]);
         v_out = (x[MSB] != y[MSB]) && (sum[MSB] != x[MSB]);
      end else begin
         h_out = (x[HB] & y[HB]) | (y[HB] & ~sum[HB]) | (~sum[HB] & x[HB]);
         v_out = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
      end
   end

   always_comb begin
      if (!sub)
         AST_ADD_CARRY_ORDER: assert (c_out == ((sum < x) || (ci && sum == x))); // R1
      if (sub)
         AST_SUB_BORROW_ORDER: assert (c_out == ((x < y) || (ci && x == y))); // R2
   end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic [1:0]       sel,
   output logic [WIDTH-1:0] r
);
   import alu8_pkg::*;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("alu8_logic: WIDTH must be positive");
      end
   endgenerate

   always_comb begin
      case (sel)
         LG_AND:  r = x & y;
         LG_OR:   r = x | y;
         LG_XOR:  r = x ^ y;
         default: r = ~x;
      endcase
   end

   always_comb begin
      if (sel == LG_NOT)
         AST_NOT_SUMS_TO_ONES: assert ((r ^ x) == {WIDTH{1'b1}}); // R5
   end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] x,
   input  logic             ci,
   input  logic [2:0]       kind,
   output logic [WIDTH-1:0] r,
   output logic             c_out
);
   import alu8_pkg::*;

   localparam int MSB = WIDTH - 1;
   localparam int NIB = WIDTH / 2;

   generate
      if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
         $error("alu8_shift: WIDTH must be even and at least 4");
      end
   endgenerate

   logic [WIDTH-1:0] swapped;

   generate
      for (genvar i = 0; i < NIB; i++) begin : g_swap
         assign swapped[i]       = x[i + NIB];
         assign swapped[i + NIB] = x[i];
      end
   endgenerate

   always_comb begin
      case (kind)
         SH_LSL:  begin r = {x[MSB-1:0], 1'b0};  c_out = x[MSB]; end
         SH_LSR:  begin r = {1'b0, x[MSB:1]};    c_out = x[0];   end
         SH_ROL:  begin r = {x[MSB-1:0], ci};    c_out = x[MSB]; end
         SH_ROR:  begin r = {ci, x[MSB:1]};      c_out = x[0];   end
         SH_ASR:  begin r = {x[MSB], x[MSB:1]};  c_out = x[0];   end
         default: begin r = swapped;             c_out = 1'b0;   end
      endcase
   end

   always_comb begin
      if (kind == SH_LSL)
         AST_LSL_ZERO_FILL: assert (r[0] == 1'b0); // R8
      if (kind == SH_ROR)
         AST_ROR_CARRY_TOP: assert (r[MSB] == ci); // R9
      if (kind == SH_ASR)
         AST_ASR_SIGN_HELD: assert (r[MSB] == x[MSB] && r[MSB-1] == x[MSB]); // R10
   end

endmodule

// File: rtl/alu8.sv
module alu8 #(
   parameter int WIDTH = 8
) (
   input  logic [4:0]       op_sel,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic             carry_in,
   input  logic [5:0]       flags_in,
   output logic [WIDTH-1:0] result,
   output logic [5:0]       flags_out,
   output logic             result_we
);
   import alu8_pkg::*;

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
         $error("alu8: WIDTH must be even and at least 4");
      end
   endgenerate

   // decode
   alu_grp_e          grp;
   logic [WIDTH-1:0]  as_x, as_y;
   logic              as_ci, as_sub;
   logic [1:0]        lg_sel;
   logic [2:0]        sh_kind;

   always_comb begin
      grp     = GRP_NONE;
      as_x    = opnd_a;
      as_y    = opnd_b;
      as_ci   = 1'b0;
      as_sub  = 1'b0;
      lg_sel  = LG_AND;
      sh_kind = SH_LSL;
      case (op_sel)
         OP_ADD:  grp = GRP_ARITH;
         OP_ADC:  begin grp = GRP_ARITH; as_ci = carry_in; end
         OP_SUB,
         OP_CMP:  begin grp = GRP_ARITH; as_sub = 1'b1; end
         OP_SBC,
         OP_CPC:  begin grp = GRP_ARITH; as_sub = 1'b1; as_ci = carry_in; end
         OP_NEG:  begin grp = GRP_ARITH; as_sub = 1'b1; as_x = '0; as_y = opnd_a; end
         OP_INC:  begin grp = GRP_ARITH; as_y = {{(WIDTH-1){1'b0}}, 1'b1}; end
         OP_DEC:  begin grp = GRP_ARITH; as_sub = 1'b1; as_y = {{(WIDTH-1){1'b0}}, 1'b1}; end
         OP_AND:  begin grp = GRP_LOGIC; lg_sel = LG_AND; end
         OP_OR:   begin grp = GRP_LOGIC; lg_sel = LG_OR;  end
         OP_XOR:  begin grp = GRP_LOGIC; lg_sel = LG_XOR; end
         OP_COM:  begin grp = GRP_LOGIC; lg_sel = LG_NOT; end
         OP_LSL:  begin grp = GRP_SHIFT; sh_kind = SH_LSL;  end
         OP_LSR:  begin grp = GRP_SHIFT; sh_kind = SH_LSR;  end
         OP_ROL:  begin grp = GRP_SHIFT; sh_kind = SH_ROL;  end
         OP_ROR:  begin grp = GRP_SHIFT; sh_kind = SH_ROR;  end
         OP_ASR:  begin grp = GRP_SHIFT; sh_kind = SH_ASR;  end
         OP_SWAP: begin grp = GRP_SHIFT; sh_kind = SH_SWAP; end
         default: grp = GRP_NONE;
      endcase
   end

   // datapath units
   logic [WIDTH-1:0] as_sum, lg_r, sh_r;
   logic             as_c, as_h, as_v, sh_c;

   alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
      .x(as_x), .y(as_y), .ci(as_ci), .sub(as_sub),
      .sum(as_sum), .c_out(as_c), .h_out(as_h), .v_out(as_v)
   );

   alu8_logic #(.WIDTH(WIDTH)) u_logic (
      .x(opnd_a), .y(opnd_b), .sel(lg_sel), .r(lg_r)
   );

   alu8_shift #(.WIDTH(WIDTH)) u_shift (
      .x(opnd_a), .ci(carry_in), .kind(sh_kind), .r(sh_r), .c_out(sh_c)
   );

   // merge
   logic [WIDTH-1:0]  res;
   logic              c_new, h_new, v_new, n_new, z_new;
   logic [FLAG_W-1:0] calc, mask;

   always_comb begin
      case (grp)
         GRP_ARITH: begin res = as_sum; c_new = as_c; h_new = as_h; v_new = as_v; end
         GRP_LOGIC: begin res = lg_r;   c_new = 1'b1; h_new = 1'b0; v_new = 1'b0; end
         GRP_SHIFT: begin res = sh_r;   c_new = sh_c; h_new = 1'b0; v_new = sh_r[MSB] ^ sh_c; end
         default:   begin res = '0;     c_new = 1'b0; h_new = 1'b0; v_new = 1'b0; end
      endcase
      n_new = res[MSB];
      z_new = (res == '0);
      calc  = '0;
      calc[F_C] = c_new;
      calc[F_Z] = z_new;
      calc[F_N] = n_new;
      calc[F_V] = v_new;
      calc[F_S] = n_new ^ v_new;
      calc[F_H] = h_new;
      mask = flag_mask(op_sel);
   end

   assign result    = res;
   assign flags_out = (flags_in & ~mask) | (calc & mask);
   assign result_we = writes_back(op_sel);

   always_comb begin
      if (op_sel == OP_CMP || op_sel == OP_CPC)
         AST_CMP_NO_WRITE: assert (!result_we); // R3
      if (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR)
         AST_LOGIC_KEEP_CH: assert (flags_out[F_C] == flags_in[F_C] && flags_out[F_H] == flags_in[F_H] && !flags_out[F_V]); // R4
      if (op_sel == OP_COM)
         AST_COM_SETS_C: assert (flags_out[F_C] && !flags_out[F_V] && flags_out[F_H] == flags_in[F_H]); // R5
      if (op_sel == OP_NEG)
         AST_NEG_CARRY_NONZERO: assert (flags_out[F_C] == (opnd_a != '0)); // R6
      if (op_sel == OP_INC || op_sel == OP_DEC)
         AST_INCDEC_KEEP_CH: assert (flags_out[F_C] == flags_in[F_C] && flags_out[F_H] == flags_in[F_H]); // R7
      if (op_sel == OP_SWAP)
         AST_SWAP_FLAGS_HELD: assert (flags_out == flags_in && result_we); // R11
      if (mask[F_V])
         AST_SIGN_RULE: assert (flags_out[F_S] == (flags_out[F_N] ^ flags_out[F_V])); // R12
      if (op_sel > OP_SWAP)
         AST_IDLE_CODE: assert (flags_out == flags_in && !result_we && result == '0); // R13
   end

endmodule

// File: tb/alu8_tb.sv
module alu8_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] op_sel = '0;
   logic [7:0] opnd_a = '0, opnd_b = '0;
   logic       carry_in = 1'b0;
   logic [5:0] flags_in = '0;
   logic [7:0] result;
   logic [5:0] flags_out;
   logic       result_we;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu8 u_dut (
      .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
      .flags_in(flags_in), .result(result), .flags_out(flags_out), .result_we(result_we)
   );

   function automatic int sgn(input int v);
      return (v >= 128) ? v - 256 : v;
   endfunction

   // independent integer model, flags {H,S,V,N,Z,C}
   function automatic void model(input int op, input int a, input int b, input int ci,
                                 input int fin, output int res, output int fo, output int we);
      int c, v, h, n, z, s, m, t, st, k, x, y, calc;
      bit sub;
      c = 0; v = 0; h = 0; m = 0; res = 0; we = 1; sub = 0; k = 0;
      case (op)
         0, 1, 2, 3, 4, 5, 10: begin
            x = a; y = b;
            if (op == 1 || op == 3 || op == 5) k = ci;
            if (op >= 2) sub = 1;
            if (op == 10) begin x = 0; y = a; end
            if (!sub) begin
               t = x + y + k; c = (t > 255); h = ((x % 16) + (y % 16) + k) > 15;
               st = sgn(x) + sgn(y) + k;
            end else begin
               t = x - y - k; c = (t < 0); h = ((x % 16) - (y % 16) - k) < 0;
               st = sgn(x) - sgn(y) - k;
            end
            res = (t + 512) % 256; v = (st > 127 || st < -128); m = 63;
            if (op == 4 || op == 5) we = 0;
         end
         6: begin res = a & b; m = 30; end
         7: begin res = a | b; m = 30; end
         8: begin res = a ^ b; m = 30; end
         9: begin res = 255 - a; c = 1; m = 31; end
         11: begin res = (a + 1) % 256; v = (a == 127); m = 30; end
         12: begin res = (a + 255) % 256; v = (a == 128); m = 30; end
         13: begin res = (a * 2) % 256; c = a / 128; m = 31; end
         14: begin res = a / 2; c = a % 2; m = 31; end
         15: begin res = (a * 2) % 256 + ci; c = a / 128; m = 31; end
         16: begin res = a / 2 + ci * 128; c = a % 2; m = 31; end
         17: begin res = a / 2 + (a / 128) * 128; c = a % 2; m = 31; end
         18: begin res = (a % 16) * 16 + a / 16; m = 0; end
         default: begin res = 0; we = 0; m = 0; end
      endcase
      n = res / 128;
      z = (res == 0);
      if (op >= 13 && op <= 17) v = n ^ c;
      s = n ^ v;
      calc = c + 2 * z + 4 * n + 8 * v + 16 * s + 32 * h;
      fo = (fin & ~m & 63) | (calc & m);
   endfunction

   task automatic chk(input string rq, input int op, input int a, input int b,
                      input int ci, input int fin);
      int er, ef, ew;
      @(posedge clk);
      op_sel = op[4:0]; opnd_a = a[7:0]; opnd_b = b[7:0];
      carry_in = ci[0]; flags_in = fin[5:0];
      @(negedge clk);
      model(op, a, b, ci, fin, er, ef, ew);
      total++;
      if (int'(result) != er || int'(flags_out) != ef || int'(result_we) != ew) begin
         bad++;
         $display("FAIL %s op=%0d a=%02h b=%02h ci=%0d fin=%02h : got res=%02h flg=%02h we=%0d exp res=%02h flg=%02h we=%0d",
                  rq, op, a, b, ci, fin, result, flags_out, result_we, er, ef, ew);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      total++;
      // all-zero inputs mean ADD 0+0: result 0, only Z set, write enabled (R1)
      if (result != 8'h00 || flags_out != 6'h02 || !result_we) begin
         bad++;
         $display("FAIL R1 reset state: got res=%02h flg=%02h we=%0d exp res=00 flg=02 we=1",
                  result, flags_out, result_we);
      end
   endtask

   task automatic t_add();
      chk("R1", 0, 8'h0F, 8'h01, 0, 0);    // half carry
      chk("R1", 0, 8'h7F, 8'h01, 1, 0);    // overflow, carry_in ignored
      chk("R1", 0, 8'hFF, 8'h01, 0, 0);    // carry, zero
      chk("R1", 1, 8'h80, 8'h7F, 1, 0);    // carry_in used
      chk("R1", 1, 8'h80, 8'h80, 0, 63);
   endtask

   task automatic t_sub();
      chk("R2", 2, 8'h10, 8'h01, 0, 0);    // nibble borrow
      chk("R2", 2, 8'h00, 8'h01, 0, 0);    // full borrow
      chk("R2", 2, 8'h80, 8'h01, 0, 0);    // signed overflow
      chk("R2", 3, 8'h05, 8'h05, 1, 0);    // borrow from carry_in
      chk("R2", 3, 8'h05, 8'h04, 1, 63);
   endtask

   task automatic t_compare();
      chk("R3", 4, 8'h33, 8'h33, 0, 0);
      chk("R3", 4, 8'h10, 8'h20, 0, 63);
      chk("R3", 5, 8'h40, 8'h40, 1, 0);
   endtask

   task automatic t_logic();
      chk("R4", 6, 8'hF0, 8'h0F, 0, 6'h21);  // zero, C/H kept
      chk("R4", 7, 8'h80, 8'h01, 0, 6'h08);  // V cleared
      chk("R4", 8, 8'hAA, 8'hAA, 0, 6'h3F);
   endtask

   task automatic t_com();
      chk("R5", 9, 8'h00, 8'h00, 0, 0);
      chk("R5", 9, 8'hFF, 8'h00, 0, 6'h28);
   endtask

   task automatic t_neg();
      chk("R6", 10, 8'h00, 8'h00, 0, 6'h01);
      chk("R6", 10, 8'h80, 8'h00, 0, 0);
      chk("R6", 10, 8'h01, 8'h00, 0, 0);
   endtask

   task automatic t_incdec();
      chk("R7", 11, 8'h7F, 8'h00, 0, 6'h21);
      chk("R7", 11, 8'hFF, 8'h00, 0, 0);
      chk("R7", 12, 8'h80, 8'h00, 0, 6'h21);
      chk("R7", 12, 8'h01, 8'h00, 1, 0);
   endtask

   task automatic t_shift();
      chk("R8", 13, 8'h81, 8'h00, 1, 6'h20);
      chk("R8", 13, 8'h40, 8'h00, 0, 0);
      chk("R8", 14, 8'h01, 8'h00, 1, 0);
      chk("R8", 14, 8'h80, 8'h00, 0, 6'h20);
   endtask

   task automatic t_rotate();
      chk("R9", 15, 8'h80, 8'h00, 1, 0);
      chk("R9", 15, 8'h01, 8'h00, 0, 0);
      chk("R9", 16, 8'h01, 8'h00, 1, 0);
      chk("R9", 16, 8'h02, 8'h00, 0, 6'h01);
   endtask

   task automatic t_asr();
      chk("R10", 17, 8'h81, 8'h00, 0, 0);
      chk("R10", 17, 8'h7E, 8'h00, 1, 0);
   endtask

   task automatic t_swap();
      chk("R11", 18, 8'h3C, 8'h00, 0, 6'h15);
      chk("R11", 18, 8'hA5, 8'h00, 1, 6'h2A);
   endtask

   task automatic t_sign();
      chk("R12", 2, 8'h7F, 8'hFF, 0, 0);    // V=1 N=1 -> S=0
      chk("R12", 0, 8'h00, 8'h00, 0, 6'h10);
   endtask

   task automatic t_idle();
      for (int op = 19; op < 32; op++) chk("R13", op, 8'h5A, 8'hC3, 1, 6'h2D);
   endtask

   task automatic t_sweep();
      int vals[9] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'h8F, 8'hA5, 8'hFF};
      for (int op = 0; op < 32; op++)
         for (int i = 0; i < 9; i++)
            for (int j = 0; j < 9; j++)
               chk("R1..R13 sweep", op, vals[i], vals[j], (i + j) % 2, (vals[i] ^ vals[j]) % 64);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset();
      t_add();
      t_sub();
      t_compare();
      t_logic();
      t_com();
      t_neg();
      t_incdec();
      t_shift();
      t_rotate();
      t_asr();
      t_swap();
      t_sign();
      t_idle();
      t_sweep();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule